// File: doc/BRIEF.md
# PCI Host Bridge Memory Window Translator

This block is the control register file of a PCI host bridge, together with the logic that turns a CPU offset into a window into a 32-bit PCI address. It holds eight 32-bit registers: an inbound map register for each of three memory windows, an identity register, a flags register and an outbound map register for each of the three windows. Software reaches them through a simple word-wide read/write port. Read data comes back one cycle after the read strobe. A bad access raises a one-cycle error pulse.

The translation side takes a window index and an offset and returns the PCI memory address at once, in the same cycle. A separate select routes the request to the fixed I/O window instead. A build-time parameter picks one of two board variants. The variants differ in the three window sizes and in how a map register becomes a window base. In one variant the low nibble of the map register supplies the top four address bits. In the other, the map register is masked down to the bits above the window size.

Top module: `pciwin_xlate_top`

## Requirements
- R1: Word offsets 0x00, 0x04 and 0x08 hold the map registers of windows 0, 1 and 2; 0x0C holds the identity register; 0x10 holds the flags register; 0x14, 0x18 and 0x1C hold the outbound map registers of windows 0, 1 and 2. Each register is fully 32-bit writable and reads back what was written. Read data appears on the cycle after the read strobe.
- R2: Only accesses with all four byte strobes set (4'hF) are valid. A write with any other strobe pattern changes no register. A read with such a pattern returns 0. Either one raises the error pulse.
- R3: For a mapped offset, bits [1:0] are zero and the bits above bit 4 are zero. A read from any other offset returns 0. A write to one changes no register and raises the error pulse.
- R4: An active-low reset clears all eight registers to zero.
- R5: With VARIANT=0, the base of a window is its map register shifted left by 28. Only map bits [3:0] matter, and they become address bits [31:28].
- R6: With VARIANT=1, the base of a window is its map register ANDed with the inverse of (window size - 1).
- R7: With VARIANT=0, the window sizes are 0x0C000000, 0x10000000 and 0x10000000. With VARIANT=1, they are 0x01000000, 0x04000000 and 0x08000000.
- R8: When a translation is requested and the offset is below the window size, xl_valid is high and xl_addr equals base plus offset, modulo 2^32. When no translation is requested, xl_valid and xl_oob are both low.
- R9: Any of the following sets xl_oob high, holds xl_valid low and drives xl_addr to 0: an offset at or above the window size, or a window index of 3.
- R10: With xl_io high, the request targets the I/O window. Its base is 0 and its size is 0x100000, and the window index is ignored.
- R11: A map register write changes the translation from the cycle after the write edge. Before that edge, the old base still applies.
- R12: bus_err is high only on the cycle after a bad access, as defined in R2 and R3. A valid access never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wstrb | input | 4 | Byte lane strobes; must be 4'hF |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| bus_err | output | 1 | One-cycle pulse after a bad access |
| xl_req | input | 1 | Translation request |
| xl_io | input | 1 | Select the I/O window instead of a memory window |
| xl_win | input | 2 | Memory window index; 3 is invalid |
| xl_offset | input | 32 | Offset into the selected window |
| xl_addr | output | 32 | Translated PCI address |
| xl_valid | output | 1 | Translation is within its window |
| xl_oob | output | 1 | Offset or index is outside any window |

## Verification
On every cycle the assertions check several properties:
- xl_valid and xl_oob are never high together, and both stay low with no request.
- An out-of-range result drives a zero address.
- Bases respect the alignment of their variant.
- A rejected write leaves the register file untouched.
- An error pulse only ever follows an access.

Only the bench scenarios can show the actual address arithmetic for each variant and window, and the window size boundaries. The same holds for the exact register offsets, the one-cycle read latency, and the cycle in which a new map value starts to steer translation.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_WIN = 3;
  localparam int NUM_REG = 8;
  localparam int IO_SIZE = 32'h0010_0000;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t win_size(input int variant, input int idx);
    word_t sz;
    if (variant == 0) begin
      case (idx)
        0:       sz = 32'h0C00_0000;
        1:       sz = 32'h1000_0000;
        2:       sz = 32'h1000_0000;
        default: sz = '0;
      endcase
    end else begin
      case (idx)
        0:       sz = 32'h0100_0000;
        1:       sz = 32'h0400_0000;
        2:       sz = 32'h0800_0000;
        default: sz = '0;
      endcase
    end
    return sz;
  endfunction
endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
  import pciwin_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [3:0]                wstrb,
  input  word_t                     wdata,
  output word_t                     rdata,
  output logic                      err,
  output logic [NUM_WIN-1:0][WORD_W-1:0] imap_o
);
  localparam int IDX_W = $clog2(NUM_REG);
  localparam int HI_LSB = IDX_W + 2;

  logic [NUM_REG-1:0][WORD_W-1:0] regs_q, regs_d;
  word_t               rdata_q, rdata_d;
  logic                err_q, err_d;
  logic                hit, full, wr_ok, rd_ok, bad;
  logic [IDX_W-1:0]    idx;

  always_comb begin
    hit   = (addr[ADDR_W-1:HI_LSB] == '0) && (addr[1:0] == 2'b00);
    full  = (wstrb == 4'hF);
    idx   = addr[HI_LSB-1:2];
    wr_ok = wr_en && hit && full;
    rd_ok = rd_en && hit && full;
    bad   = (wr_en || rd_en) && !(hit && full);

    regs_d = regs_q;
    if (wr_ok) regs_d[idx] = wdata;

    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_ok ? regs_q[idx] : '0;

    err_d = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_ok) regs_q <= regs_d;
      if (rd_en) rdata_q <= rdata_d;
      err_q <= err_d;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_imap
    assign imap_o[w] = regs_q[w];
  end

  assign rdata = rdata_q;
  assign err   = err_q;

  // R2 / R3: a rejected write leaves every register as it was
  p_rejected_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(hit && full)) |=> $stable(regs_q));
  // R3: unmapped read returns zero
  p_unmapped_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == '0));
  // R12: error pulse only after some access
  p_err_after_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en || rd_en));
endmodule

// File: rtl/pciwin_base.sv
module pciwin_base
  import pciwin_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_WIN-1:0][WORD_W-1:0] imap,
  output logic [NUM_WIN-1:0][WORD_W-1:0] base
);
  localparam int NIB_SHIFT = WORD_W - 4;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam word_t SZ = win_size(VARIANT, w);
    if (VARIANT == 0) begin : g_nibble
      assign base[w] = word_t'(imap[w] << NIB_SHIFT);
      // R5: only the top nibble of the base can be set
      p_nibble_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        base[w][NIB_SHIFT-1:0] == '0);
    end else begin : g_masked
      assign base[w] = imap[w] & ~(SZ - 1);
      // R6: base is aligned to its window size
      p_size_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (base[w] & (SZ - 1)) == '0);
    end
  end
endmodule

// File: rtl/pciwin_xlate.sv
module pciwin_xlate
  import pciwin_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_WIN-1:0][WORD_W-1:0] base,
  input  logic                           req,
  input  logic                           io,
  input  logic [1:0]                     win,
  input  word_t                          offset,
  output word_t                          addr,
  output logic                           valid,
  output logic                           oob
);
  word_t sel_base, sel_size;
  logic  in_range;

  always_comb begin
    sel_base = '0;
    sel_size = '0;
    if (io) begin
      sel_size = word_t'(IO_SIZE);
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (win == w[1:0]) begin
          sel_base = base[w];
          sel_size = win_size(VARIANT, w);
        end
      end
    end
    in_range = offset < sel_size;
    valid    = req && in_range;
    oob      = req && !in_range;
    addr     = valid ? (sel_base + offset) : '0;
  end

  // R9: valid and out-of-range are exclusive
  p_valid_oob_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && oob));
  // R8: idle request drives neither flag
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!valid && !oob));
  // R9: out-of-range result carries a zero address
  p_oob_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oob |-> (addr == '0));
endmodule

// File: rtl/pciwin_xlate_top.sv
module pciwin_xlate_top
  import pciwin_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_wstrb,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              xl_req,
  input  logic              xl_io,
  input  logic [1:0]        xl_win,
  input  logic [31:0]       xl_offset,
  output logic [31:0]       xl_addr,
  output logic              xl_valid,
  output logic              xl_oob
);
  logic [NUM_WIN-1:0][WORD_W-1:0] imap, base;

  pciwin_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wstrb(bus_wstrb), .wdata(bus_wdata),
    .rdata(bus_rdata), .err(bus_err), .imap_o(imap)
  );

  pciwin_base #(.VARIANT(VARIANT)) u_base (
    .clk(clk), .rst_n(rst_n), .imap(imap), .base(base)
  );

  pciwin_xlate #(.VARIANT(VARIANT)) u_xlate (
    .clk(clk), .rst_n(rst_n), .base(base), .req(xl_req), .io(xl_io),
    .win(xl_win), .offset(xl_offset), .addr(xl_addr), .valid(xl_valid),
    .oob(xl_oob)
  );
endmodule

// File: tb/pciwin_xlate_top_tb.sv
module pciwin_xlate_top_tb_top;
  localparam int ADDR_W = 12;
  localparam int NVEC = 10;

  // {variant, win[1:0], imap[31:0], offset[31:0], exp_addr[31:0], exp_oob}
  localparam logic [99:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 32'h0000_0005, 32'h0000_1234, 32'h5000_1234, 1'b0},
    {1'b0, 2'd0, 32'h0000_0005, 32'h0BFF_FFFF, 32'h5BFF_FFFF, 1'b0},
    {1'b0, 2'd0, 32'h0000_0005, 32'h0C00_0000, 32'h0000_0000, 1'b1},
    {1'b0, 2'd1, 32'hFFFF_FFFA, 32'h0FFF_FFFF, 32'hAFFF_FFFF, 1'b0},
    {1'b0, 2'd2, 32'h0000_0003, 32'h1000_0000, 32'h0000_0000, 1'b1},
    {1'b0, 2'd2, 32'h0000_000F, 32'h0000_0010, 32'hF000_0010, 1'b0},
    {1'b1, 2'd0, 32'h1234_5678, 32'h00AB_CDEF, 32'h12AB_CDEF, 1'b0},
    {1'b1, 2'd1, 32'h8765_4321, 32'h03FF_FFFF, 32'h87FF_FFFF, 1'b0},
    {1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0800_0000, 32'h0000_0000, 1'b1},
    {1'b1, 2'd2, 32'h0FFF_FFFF, 32'h0700_0001, 32'h0F00_0001, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr_en, bus_rd_en;
  logic [ADDR_W-1:0] bus_addr;
  logic [3:0]  bus_wstrb;
  logic [31:0] bus_wdata;
  logic xl_req, xl_io;
  logic [1:0]  xl_win;
  logic [31:0] xl_offset;
  logic [31:0] rd_a, rd_b, xa_a, xa_b;
  logic err_a, err_b, va_a, va_b, oo_a, oo_b;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pciwin_xlate_top #(.ADDR_W(ADDR_W), .VARIANT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(rd_a), .bus_err(err_a), .xl_req(xl_req), .xl_io(xl_io),
    .xl_win(xl_win), .xl_offset(xl_offset), .xl_addr(xa_a),
    .xl_valid(va_a), .xl_oob(oo_a)
  );

  pciwin_xlate_top #(.ADDR_W(ADDR_W), .VARIANT(1)) dut_rv_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(rd_b), .bus_err(err_b), .xl_req(xl_req), .xl_io(xl_io),
    .xl_win(xl_win), .xl_offset(xl_offset), .xl_addr(xa_b),
    .xl_valid(va_b), .xl_oob(oo_b)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                           input logic [3:0] s);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [3:0] s);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a; bus_wstrb = s;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0; bus_wstrb = 4'hF;
    bus_wdata = '0; xl_req = 1'b0; xl_io = 1'b0; xl_win = '0; xl_offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state of every register
    for (int r = 0; r < 8; r++) begin
      bus_read(ADDR_W'(r * 4), 4'hF);
      check(rd_a == 32'd0 && rd_b == 32'd0, "R4 reset value", rd_a, 32'd0);
    end
    // R8: no request, both flags low
    check(!va_a && !oo_a && !va_b && !oo_b, "R8 idle flags",
          {30'd0, va_a, oo_a}, 32'd0);

    // R5 R6 R7 R8 R9: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic        var_s;
      logic [1:0]  w;
      logic [31:0] mp, off, ea;
      logic        eo;
      {var_s, w, mp, off, ea, eo} = VEC[v];
      bus_write(ADDR_W'(w * 4), mp, 4'hF);
      xl_req = 1'b1; xl_io = 1'b0; xl_win = w; xl_offset = off;
      #2;
      if (var_s == 1'b0)
        check(xa_a == ea && oo_a == eo && va_a == !eo, "R5 R7 R8 R9 nibble vector",
              xa_a, ea);
      else
        check(xa_b == ea && oo_b == eo && va_b == !eo, "R6 R7 R8 R9 masked vector",
              xa_b, ea);
      xl_req = 1'b0;
    end

    // R9: window index 3 is invalid
    @(negedge clk);
    xl_req = 1'b1; xl_win = 2'd3; xl_offset = 32'd0;
    #2;
    check(oo_a && !va_a && xa_a == 0 && oo_b && !va_b, "R9 window index 3",
          {31'd0, oo_a}, 32'd1);

    // R10: I/O window, index ignored
    xl_io = 1'b1; xl_win = 2'd1; xl_offset = 32'h000F_FFFF;
    #2;
    check(va_a && xa_a == 32'h000F_FFFF && va_b && xa_b == 32'h000F_FFFF,
          "R10 io last byte", xa_a, 32'h000F_FFFF);
    xl_offset = 32'h0010_0000;
    #2;
    check(oo_a && !va_a && oo_b, "R10 io past end", {31'd0, oo_a}, 32'd1);
    xl_io = 1'b0; xl_req = 1'b0;

    // R1: distinct values in all eight registers, read back by offset
    for (int r = 0; r < 8; r++) bus_write(ADDR_W'(r * 4), 32'hA5A5_0000 + r, 4'hF);
    for (int r = 0; r < 8; r++) begin
      bus_read(ADDR_W'(r * 4), 4'hF);
      check(rd_a == 32'hA5A5_0000 + r && rd_b == rd_a && !err_a,
            "R1 R12 register readback", rd_a, 32'hA5A5_0000 + r);
    end

    // R2: partial-strobe write ignored, error raised, read gives 0
    bus_write(ADDR_W'(8'h0C), 32'hDEAD_BEEF, 4'h3);
    check(err_a && err_b, "R2 R12 partial write error", {31'd0, err_a}, 32'd1);
    bus_read(ADDR_W'(8'h0C), 4'hF);
    check(rd_a == 32'hA5A5_0003 && !err_a, "R2 partial write ignored",
          rd_a, 32'hA5A5_0003);
    bus_read(ADDR_W'(8'h0C), 4'h1);
    check(rd_a == 32'd0 && err_a, "R2 partial read zero", rd_a, 32'd0);

    // R3: unmapped offsets
    bus_write(ADDR_W'(12'h020), 32'h1111_1111, 4'hF);
    check(err_a, "R3 unmapped write error", {31'd0, err_a}, 32'd1);
    bus_write(ADDR_W'(12'h011), 32'h2222_2222, 4'hF);
    check(err_a, "R3 misaligned write error", {31'd0, err_a}, 32'd1);
    bus_read(ADDR_W'(12'h020), 4'hF);
    check(rd_a == 32'd0 && err_a, "R3 unmapped read zero", rd_a, 32'd0);
    for (int r = 0; r < 8; r++) begin
      bus_read(ADDR_W'(r * 4), 4'hF);
      check(rd_a == 32'hA5A5_0000 + r, "R3 registers untouched",
            rd_a, 32'hA5A5_0000 + r);
    end

    // R11: new map value only after the write edge
    bus_write(ADDR_W'(0), 32'h0000_0001, 4'hF);
    @(negedge clk);
    xl_req = 1'b1; xl_win = 2'd0; xl_offset = 32'h10;
    bus_wr_en = 1'b1; bus_addr = '0; bus_wdata = 32'h0000_0007; bus_wstrb = 4'hF;
    #2;
    check(xa_a == 32'h1000_0010, "R11 old base before edge", xa_a, 32'h1000_0010);
    @(negedge clk);
    bus_wr_en = 1'b0;
    #2;
    check(xa_a == 32'h7000_0010, "R11 new base after edge", xa_a, 32'h7000_0010);
    xl_req = 1'b0;

    // R4: reset after traffic clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 8; r++) begin
      bus_read(ADDR_W'(r * 4), 4'hF);
      check(rd_a == 32'd0 && rd_b == 32'd0, "R4 reset clears", rd_a, 32'd0);
    end

    summary();
  end
endmodule